// File: doc/BRIEF.md
# ATA Task-File Register Controller

This block is the device-side register file of a parallel ATA disk port. A host bus addresses eight byte-wide registers with a 3-bit offset. Some registers have one meaning on a write and another on a read. The block keeps the command parameters (sector count, a 24-bit block address assembled from three bytes, and a device-select byte). It accepts a small set of command opcodes and presents a status byte, an error byte and a level interrupt line.

IDENTIFY is handled internally. The block enters a data phase and sources a fixed buffer of words through the 16-bit data register, one word per read. A cache flush is handed to the storage back end through a request/done/error handshake. The four data-moving opcodes are handed to an external bus-master engine through a request and direction signal, and complete on that engine's done pulse. Any other opcode aborts at once. Reading the status byte acknowledges the interrupt.

Top module: `ata_taskfile`

## Requirements
- R1: After reset the status byte reads 0x40 (only the ready bit set), the error byte reads 0x00, and the interrupt, back-end request and DMA request outputs are low.
- R2: Offsets 2 to 6 (count, address low, address mid, address high, device) read back the byte last written to them. Offset 1 reads the error byte and offset 7 reads the status byte. The upper 8 bits of any non-data read are zero.
- R3: The `cmdLba` output equals {offset 5, offset 4, offset 3}. The `cmdCount` output equals the offset 2 byte, except that a byte of zero gives 256.
- R4: Opcode 0xEC makes the status byte read 0x48 (ready plus data-request, bit 3) on the next cycle and raises the interrupt. Each read of offset 0 then returns word n = {~n[7:0], n[7:0]} for n = 0..255 in order. After the 256th read the status byte is 0x40. Offset 0 reads 0x0000 when no data phase is active.
- R5: Opcode 0xE7 makes the status byte read 0xC0 (busy plus ready) and holds `beReq` high until a `beDone` pulse. It then returns to 0x40 with the interrupt raised.
- R6: Opcodes 0xC8, 0xCA, 0xA0 and 0x06 make the status byte read 0xC0 and hold `dmaReq` high until a `dmaDone` pulse. `dmaToHost` is 1 for 0xC8 and 0xA0 and 0 for 0xCA and 0x06. Completion returns the status byte to 0x40 and raises the interrupt.
- R7: A completion whose error flag (`beErr` with `beDone`, or `dmaErr` with `dmaDone`) is high leaves the status byte at 0x41 (ready plus error, bit 0) and the error byte at 0x04 (abort, bit 2).
- R8: Any opcode outside the supported six gives status 0x41, error byte 0x04 and a raised interrupt on the next cycle, with no request issued.
- R9: A read of offset 7 clears the interrupt. A read of offset 1 leaves it set. A completion in the same cycle as a status read leaves the interrupt set.
- R10: While busy (status bit 7), command writes and writes to offsets 2 to 6 are ignored.
- R11: Commands are ignored when device-byte bit 4 differs from the `DEV_ID` parameter (default 0).
- R12: An accepted command clears the error bit and the error byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 3 | Register offset |
| hostWrEn | input | 1 | Write strobe, one per cycle |
| hostWrData | input | 8 | Write byte |
| hostRdEn | input | 1 | Read strobe; triggers read side effects |
| hostRdData | output | 16 | Read data for the addressed offset |
| intrq | output | 1 | Level interrupt to the host |
| cmdLba | output | 24 | Assembled block address |
| cmdCount | output | 9 | Sector count, 1 to 256 |
| beReq | output | 1 | Flush request to the back end |
| beDone | input | 1 | Back-end completion pulse |
| beErr | input | 1 | Back-end failure, valid with beDone |
| dmaReq | output | 1 | Transfer request to the bus-master engine |
| dmaToHost | output | 1 | Transfer direction, 1 = device to host |
| dmaDone | input | 1 | Bus-master completion pulse |
| dmaErr | input | 1 | Bus-master failure, valid with dmaDone |

## Verification
The hardest state to reach is a command arriving while another is in progress. The stimulus issues a flush in the middle of an IDENTIFY data phase, which is legal because that phase is not busy. It then tries a new opcode and a count write while the flush is outstanding, before releasing the back end. A flush-with-failure is followed directly by a good command, to show that the error state is cleared on acceptance. A behavioural model in the bench tracks every output on every cycle, so each of these interleavings is compared cycle by cycle rather than only at its end.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

  // register offsets (behavioural: the host decodes these)
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_ERRF = 3'd1;
  localparam logic [2:0] OFS_CNT  = 3'd2;
  localparam logic [2:0] OFS_LBAL = 3'd3;
  localparam logic [2:0] OFS_LBAM = 3'd4;
  localparam logic [2:0] OFS_LBAH = 3'd5;
  localparam logic [2:0] OFS_DEV  = 3'd6;
  localparam logic [2:0] OFS_CMD  = 3'd7;

  localparam int TF_FIRST = 2;
  localparam int TF_LAST  = 6;

  localparam logic [7:0] ST_BSY  = 8'h80;
  localparam logic [7:0] ST_DRDY = 8'h40;
  localparam logic [7:0] ST_DRQ  = 8'h08;
  localparam logic [7:0] ST_ERR  = 8'h01;
  localparam logic [7:0] ERR_ABRT = 8'h04;

  localparam logic [7:0] OP_RD_DMA = 8'hC8;
  localparam logic [7:0] OP_WR_DMA = 8'hCA;
  localparam logic [7:0] OP_FLUSH  = 8'hE7;
  localparam logic [7:0] OP_IDENT  = 8'hEC;
  localparam logic [7:0] OP_PKT    = 8'hA0;
  localparam logic [7:0] OP_DSM    = 8'h06;

  typedef enum logic [1:0] {
    CS_IDLE,
    CS_IDENT,
    CS_FLUSH,
    CS_DMA
  } ctrlStateT;

  typedef struct packed {
    logic tfWrAllow;
    logic errClear;
    logic errAbort;
    logic identStart;
    logic identStep;
  } dpStrobesT;

  function automatic logic [15:0] identWord(input logic [7:0] low);
    return {~low, low};
  endfunction

endpackage

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
  import ata_tf_pkg::*;
#(
  parameter int ID_WORDS = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic [7:0]  hostWrData,
  input  dpStrobesT   strb,
  input  logic [7:0]  statusByte,
  output logic [15:0] hostRdData,
  output logic        devSel,
  output logic [23:0] cmdLba,
  output logic [8:0]  cmdCount,
  output logic        identLast,
  output logic [7:0]  errCode
);

  localparam int IDX_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;

  logic [7:0]       tfFile [TF_FIRST:TF_LAST];
  logic [7:0]       errReg;
  logic [IDX_W-1:0] wordIdx;
  logic [15:0]      idxWide;
  logic             drqOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = TF_FIRST; i <= TF_LAST; i++) tfFile[i] <= '0;
    end else if (hostWrEn && strb.tfWrAllow) begin
      for (int i = TF_FIRST; i <= TF_LAST; i++)
        if (hostAddr == 3'(i)) tfFile[i] <= hostWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               errReg <= '0;
    else if (strb.errAbort)  errReg <= ERR_ABRT;
    else if (strb.errClear)  errReg <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordIdx <= '0;
    else if (strb.identStart) wordIdx <= '0;
    else if (strb.identStep)  wordIdx <= wordIdx + 1'b1;
  end

  assign identLast = (wordIdx == IDX_W'(ID_WORDS - 1));
  assign idxWide   = 16'(wordIdx);
  assign drqOn     = (statusByte & ST_DRQ) != 8'h00;
  assign devSel    = tfFile[OFS_DEV][4];
  assign cmdLba    = {tfFile[OFS_LBAH], tfFile[OFS_LBAM], tfFile[OFS_LBAL]};
  assign cmdCount  = (tfFile[OFS_CNT] == 8'h00) ? 9'd256 : {1'b0, tfFile[OFS_CNT]};
  assign errCode   = errReg;

  always_comb begin
    hostRdData = 16'h0000;
    unique case (hostAddr)
      OFS_DATA: hostRdData = drqOn ? identWord(idxWide[7:0]) : 16'h0000;
      OFS_ERRF: hostRdData = {8'h00, errReg};
      OFS_CNT:  hostRdData = {8'h00, tfFile[OFS_CNT]};
      OFS_LBAL: hostRdData = {8'h00, tfFile[OFS_LBAL]};
      OFS_LBAM: hostRdData = {8'h00, tfFile[OFS_LBAM]};
      OFS_LBAH: hostRdData = {8'h00, tfFile[OFS_LBAH]};
      OFS_DEV:  hostRdData = {8'h00, tfFile[OFS_DEV]};
      OFS_CMD:  hostRdData = {8'h00, statusByte};
      default:  hostRdData = 16'h0000;
    endcase
  end

  // R4
  ident_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.identStep && !strb.identStart && !identLast |=> wordIdx == $past(wordIdx) + 1'b1);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tfWrAllow |=> $stable(cmdLba) && $stable(cmdCount) && $stable(devSel));

endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
#(
  parameter bit DEV_ID = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hostAddr,
  input  logic       hostWrEn,
  input  logic       hostRdEn,
  input  logic [7:0] cmdByte,
  input  logic       devSel,
  input  logic       identLast,
  input  logic       beDone,
  input  logic       beErr,
  input  logic       dmaDone,
  input  logic       dmaErr,
  output dpStrobesT  strb,
  output logic [7:0] statusByte,
  output logic       intrq,
  output logic       beReq,
  output logic       dmaReq,
  output logic       dmaToHost
);

  ctrlStateT state;
  logic errFlag, intrFlag, toHost;
  logic bsy, drq, cmdWr, accept, stsRead, intrSet;
  logic flushEnd, dmaEnd, identStep;
  logic opIdent, opFlush, opDmaIn, opDma, opBad;

  assign bsy     = (state == CS_FLUSH) || (state == CS_DMA);
  assign drq     = (state == CS_IDENT);
  assign cmdWr   = hostWrEn && (hostAddr == OFS_CMD);
  assign accept  = cmdWr && !bsy && (devSel == DEV_ID);
  assign stsRead = hostRdEn && (hostAddr == OFS_CMD);

  assign opIdent = (cmdByte == OP_IDENT);
  assign opFlush = (cmdByte == OP_FLUSH);
  assign opDmaIn = (cmdByte == OP_RD_DMA) || (cmdByte == OP_PKT);
  assign opDma   = opDmaIn || (cmdByte == OP_WR_DMA) || (cmdByte == OP_DSM);
  assign opBad   = !(opIdent || opFlush || opDma);

  assign flushEnd  = (state == CS_FLUSH) && beDone;
  assign dmaEnd    = (state == CS_DMA) && dmaDone;
  assign identStep = drq && hostRdEn && (hostAddr == OFS_DATA);
  assign intrSet   = (accept && (opIdent || opBad)) || flushEnd || dmaEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= CS_IDLE;
      errFlag  <= 1'b0;
      intrFlag <= 1'b0;
      toHost   <= 1'b0;
    end else begin
      intrFlag <= intrSet | (intrFlag & ~stsRead);
      if (accept) begin
        errFlag <= opBad;
        if (opIdent)      state <= CS_IDENT;
        else if (opFlush) state <= CS_FLUSH;
        else if (opDma) begin
          state  <= CS_DMA;
          toHost <= opDmaIn;
        end else          state <= CS_IDLE;
      end else if (flushEnd) begin
        state   <= CS_IDLE;
        errFlag <= beErr;
      end else if (dmaEnd) begin
        state   <= CS_IDLE;
        errFlag <= dmaErr;
      end else if (identStep && identLast) begin
        state <= CS_IDLE;
      end
    end
  end

  always_comb begin
    strb.tfWrAllow  = !bsy;
    strb.errClear   = accept;
    strb.errAbort   = (accept && opBad) || (flushEnd && beErr) || (dmaEnd && dmaErr);
    strb.identStart = accept && opIdent;
    strb.identStep  = identStep;
  end

  assign statusByte = (bsy ? ST_BSY : 8'h00) | ST_DRDY |
                      (drq ? ST_DRQ : 8'h00) | (errFlag ? ST_ERR : 8'h00);
  assign intrq     = intrFlag;
  assign beReq     = (state == CS_FLUSH);
  assign dmaReq    = (state == CS_DMA);
  assign dmaToHost = toHost;

  // R9
  intr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stsRead && !intrSet |=> !intrq);

  // R10
  busy_cmd_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    beReq && !beDone |=> beReq);

  // R6
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({beReq, dmaReq, drq}));

endmodule

// File: rtl/ata_taskfile.sv
module ata_taskfile
  import ata_tf_pkg::*;
#(
  parameter int ID_WORDS = 256,
  parameter bit DEV_ID   = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic [7:0]  hostWrData,
  input  logic        hostRdEn,
  output logic [15:0] hostRdData,
  output logic        intrq,
  output logic [23:0] cmdLba,
  output logic [8:0]  cmdCount,
  output logic        beReq,
  input  logic        beDone,
  input  logic        beErr,
  output logic        dmaReq,
  output logic        dmaToHost,
  input  logic        dmaDone,
  input  logic        dmaErr
);

  dpStrobesT  strb;
  logic [7:0] statusByte;
  logic [7:0] errCode;
  logic       devSel;
  logic       identLast;

  ata_tf_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .cmdByte(hostWrData), .devSel(devSel),
    .identLast(identLast), .beDone(beDone), .beErr(beErr),
    .dmaDone(dmaDone), .dmaErr(dmaErr), .strb(strb),
    .statusByte(statusByte), .intrq(intrq), .beReq(beReq),
    .dmaReq(dmaReq), .dmaToHost(dmaToHost)
  );

  ata_tf_regs #(.ID_WORDS(ID_WORDS)) u_regs (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .strb(strb), .statusByte(statusByte),
    .hostRdData(hostRdData), .devSel(devSel), .cmdLba(cmdLba),
    .cmdCount(cmdCount), .identLast(identLast), .errCode(errCode)
  );

  // R7
  err_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte & ST_ERR) != 8'h00 |-> errCode == ERR_ABRT);

endmodule

// File: tb/ata_taskfile_bench.sv
module ata_taskfile_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic [15:0] hostRdData;
  logic        intrq;
  logic [23:0] cmdLba;
  logic [8:0]  cmdCount;
  logic        beReq, beDone = 1'b0, beErr = 1'b0;
  logic        dmaReq, dmaToHost, dmaDone = 1'b0, dmaErr = 1'b0;

  always #10 clk = ~clk;

  ata_taskfile u_ata_taskfile (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .intrq(intrq), .cmdLba(cmdLba), .cmdCount(cmdCount), .beReq(beReq),
    .beDone(beDone), .beErr(beErr), .dmaReq(dmaReq), .dmaToHost(dmaToHost),
    .dmaDone(dmaDone), .dmaErr(dmaErr)
  );

  int    nCmp = 0;
  int    nBad = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  // behavioural reference: 0 idle, 1 identify data, 2 flush, 3 transfer
  int       mMode = 0;
  int       mIdx = 0;
  bit       mErr = 1'b0;
  bit       mIntr = 1'b0;
  bit       mToHost = 1'b0;
  bit [7:0] mErrByte = 8'h00;
  bit [7:0] mTf [2:6] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

  function automatic logic [7:0] mStatus();
    logic [7:0] s;
    s = 8'h40;
    if (mMode >= 2) s = s | 8'h80;
    if (mMode == 1) s = s | 8'h08;
    if (mErr)       s = s | 8'h01;
    return s;
  endfunction

  function automatic logic [15:0] expRd(input logic [2:0] a);
    logic [7:0] lo;
    lo = 8'(mIdx);
    if (a == 3'd0) return (mMode == 1) ? {~lo, lo} : 16'h0000;
    if (a == 3'd1) return {8'h00, mErrByte};
    if (a == 3'd7) return {8'h00, mStatus()};
    return {8'h00, mTf[a]};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mIdx = 0; mErr = 0; mIntr = 0; mToHost = 0; mErrByte = 0;
      for (int i = 2; i <= 6; i++) mTf[i] = 8'h00;
    end else begin
      bit busy, raise;
      busy = (mMode >= 2);
      raise = 1'b0;
      if (hostWrEn && hostAddr == 3'd7 && !busy && mTf[6][4] == 1'b0) begin
        mErr = 0; mErrByte = 8'h00;
        case (hostWrData)
          8'hEC: begin mMode = 1; mIdx = 0; raise = 1; end
          8'hE7: mMode = 2;
          8'hC8, 8'hA0: begin mMode = 3; mToHost = 1; end
          8'hCA, 8'h06: begin mMode = 3; mToHost = 0; end
          default: begin mMode = 0; mErr = 1; mErrByte = 8'h04; raise = 1; end
        endcase
      end else if (mMode == 2 && beDone) begin
        mMode = 0; raise = 1;
        if (beErr) begin mErr = 1; mErrByte = 8'h04; end
      end else if (mMode == 3 && dmaDone) begin
        mMode = 0; raise = 1;
        if (dmaErr) begin mErr = 1; mErrByte = 8'h04; end
      end else if (mMode == 1 && hostRdEn && hostAddr == 3'd0) begin
        if (mIdx == 255) mMode = 0;
        else mIdx = mIdx + 1;
      end
      if (hostWrEn && !busy && hostAddr >= 3'd2 && hostAddr <= 3'd6)
        mTf[hostAddr] = hostWrData;
      if (raise) mIntr = 1;
      else if (hostRdEn && hostAddr == 3'd7) mIntr = 0;
    end
  end

  task automatic cmpVal(input string what, input string req,
                        input logic [31:0] got, input logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      cmpVal("hostRdData", curReq, 32'(hostRdData), 32'(expRd(hostAddr)));
      cmpVal("intrq", curReq, 32'(intrq), 32'(mIntr));
      cmpVal("beReq", curReq, 32'(beReq), 32'(mMode == 2));
      cmpVal("dmaReq", curReq, 32'(dmaReq), 32'(mMode == 3));
      cmpVal("dmaToHost", curReq, 32'(dmaToHost), 32'(mToHost));
      cmpVal("cmdLba", curReq, 32'(cmdLba), {8'h00, mTf[5], mTf[4], mTf[3]});
      cmpVal("cmdCount", curReq, 32'(cmdCount), (mTf[2] == 8'h00) ? 32'd256 : 32'(mTf[2]));
    end
  end

  task automatic summary();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      nBad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      summary();
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    step();
    hostWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    hostAddr = a; hostRdEn = 1'b1;
    #2 v = hostRdData;
    step();
    hostRdEn = 1'b0;
  endtask

  task automatic beFinish(input logic e);
    beDone = 1'b1; beErr = e;
    step();
    beDone = 1'b0; beErr = 1'b0;
  endtask

  task automatic dmaFinish(input logic e);
    dmaDone = 1'b1; dmaErr = e;
    step();
    dmaDone = 1'b0; dmaErr = 1'b0;
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    cmpVal(what, req, got, exp);
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    step();

    curReq = "R1";
    rd(3'd7, v); check("R1", "reset status", 32'(v), 32'h40);
    rd(3'd1, v); check("R1", "reset error", 32'(v), 32'h00);
    check("R1", "reset intrq", 32'(intrq), 32'h0);
    check("R1", "reset requests", 32'({beReq, dmaReq}), 32'h0);

    curReq = "R2";
    wr(3'd2, 8'h00); wr(3'd3, 8'h12); wr(3'd4, 8'h34); wr(3'd5, 8'h56); wr(3'd6, 8'h40);
    rd(3'd3, v); check("R2", "lba low readback", 32'(v), 32'h12);
    rd(3'd4, v); check("R2", "lba mid readback", 32'(v), 32'h34);
    rd(3'd5, v); check("R2", "lba high readback", 32'(v), 32'h56);
    rd(3'd6, v); check("R2", "device readback", 32'(v), 32'h40);

    curReq = "R3";
    check("R3", "lba assembly", 32'(cmdLba), 32'h563412);
    check("R3", "count zero", 32'(cmdCount), 32'd256);
    wr(3'd2, 8'h05);
    check("R3", "count five", 32'(cmdCount), 32'd5);

    curReq = "R4";
    rd(3'd0, v); check("R4", "data idle", 32'(v), 32'h0000);
    wr(3'd7, 8'hEC);
    check("R4", "identify intrq", 32'(intrq), 32'h1);
    rd(3'd7, v); check("R4", "identify status", 32'(v), 32'h48);
    check("R9", "status read clears", 32'(intrq), 32'h0);
    for (int n = 0; n < 256; n++) begin
      logic [7:0] lo;
      lo = 8'(n);
      rd(3'd0, v);
      check("R4", "identify word", 32'(v), 32'({~lo, lo}));
    end
    rd(3'd7, v); check("R4", "status after words", 32'(v), 32'h40);
    rd(3'd0, v); check("R4", "data after phase", 32'(v), 32'h0000);

    curReq = "R8";
    wr(3'd7, 8'h55);
    rd(3'd1, v); check("R8", "bad opcode error", 32'(v), 32'h04);
    check("R9", "error read keeps intrq", 32'(intrq), 32'h1);
    rd(3'd7, v); check("R8", "bad opcode status", 32'(v), 32'h41);
    check("R9", "intrq cleared", 32'(intrq), 32'h0);

    curReq = "R12";
    wr(3'd7, 8'hEC);
    rd(3'd7, v); check("R12", "error cleared on accept", 32'(v), 32'h48);
    rd(3'd1, v); check("R12", "error byte cleared", 32'(v), 32'h00);
    rd(3'd0, v); rd(3'd0, v);

    curReq = "R5";
    wr(3'd7, 8'hE7);
    rd(3'd7, v); check("R5", "flush status", 32'(v), 32'hC0);
    check("R5", "flush request", 32'(beReq), 32'h1);
    curReq = "R10";
    wr(3'd7, 8'hC8);
    wr(3'd2, 8'h09);
    check("R10", "busy count write ignored", 32'(cmdCount), 32'd5);
    check("R10", "busy command ignored", 32'(dmaReq), 32'h0);
    rd(3'd7, v); check("R10", "still busy", 32'(v), 32'hC0);
    repeat (3) step();
    curReq = "R5";
    beFinish(1'b0);
    check("R5", "flush done intrq", 32'(intrq), 32'h1);
    rd(3'd7, v); check("R5", "flush done status", 32'(v), 32'h40);

    curReq = "R7";
    wr(3'd7, 8'hE7);
    step();
    beFinish(1'b1);
    rd(3'd7, v); check("R7", "flush fail status", 32'(v), 32'h41);
    rd(3'd1, v); check("R7", "flush fail error", 32'(v), 32'h04);

    curReq = "R6";
    wr(3'd7, 8'hC8);
    check("R6", "read dma request", 32'(dmaReq), 32'h1);
    check("R6", "read dma dir", 32'(dmaToHost), 32'h1);
    rd(3'd7, v); check("R6", "dma busy status", 32'(v), 32'hC0);
    dmaFinish(1'b0);
    rd(3'd7, v); check("R6", "dma done status", 32'(v), 32'h40);
    wr(3'd7, 8'hCA);
    check("R6", "write dma dir", 32'(dmaToHost), 32'h0);
    step();
    curReq = "R7";
    dmaFinish(1'b1);
    rd(3'd7, v); check("R7", "dma fail status", 32'(v), 32'h41);
    rd(3'd1, v); check("R7", "dma fail error", 32'(v), 32'h04);
    curReq = "R6";
    wr(3'd7, 8'hA0);
    check("R6", "packet dir", 32'(dmaToHost), 32'h1);
    dmaFinish(1'b0);
    wr(3'd7, 8'h06);
    check("R6", "dsm dir", 32'(dmaToHost), 32'h0);
    check("R6", "dsm request", 32'(dmaReq), 32'h1);
    // completion and status read in the same cycle: set wins
    hostAddr = 3'd7; hostRdEn = 1'b1; dmaDone = 1'b1;
    step();
    hostRdEn = 1'b0; dmaDone = 1'b0;
    check("R9", "set beats clear", 32'(intrq), 32'h1);
    rd(3'd7, v);

    curReq = "R11";
    wr(3'd6, 8'h50);
    wr(3'd7, 8'hE7);
    check("R11", "other device flush ignored", 32'(beReq), 32'h0);
    wr(3'd7, 8'hEC);
    rd(3'd7, v); check("R11", "other device status", 32'(v), 32'h40);
    check("R11", "other device intrq", 32'(intrq), 32'h0);
    wr(3'd6, 8'h40);
    wr(3'd7, 8'hE7);
    check("R11", "own device flush", 32'(beReq), 32'h1);
    beFinish(1'b0);
    rd(3'd7, v);
    repeat (2) step();

    summary();
  end

endmodule